// File: doc/BRIEF.md
# Zoom and Pan Scanout Address Generator

This block produces the linear pixel-memory read address for every displayed pixel of a raster screen whose picture can be panned and magnified by an integer factor. A timing generator supplies a display-enable level and a vertical-blank level. For each enabled pixel clock the block issues one address. With a zoom factor z, each source pixel is repeated for z clocks across the line and each source row is repeated for z lines down the frame. The first zoomed pixel of every line and the first zoomed row of the frame may be shortened by programmable offsets. Two row pitches can be selected, 1152 or 1024 pixels.

The settings come in as plain inputs: a 20-bit pan origin split into a 16-bit high part and a 4-bit low part, the zoom factor minus one, a line offset, a pixel offset given in steps of four, and a zoom-stop line given in steps of four. The settings are copied into a working set only when vertical blanking begins, so a frame is never drawn under two settings. From the zoom-stop line downward the frame is drawn at zoom 1. Fetching memory, shifting out pixels and generating sync are done outside the block.

Top module: `zp_scan_top`

## Requirements
- R1: While reset is asserted and after it is released, `addrValid` is 0 and `pixAddr` is 0 until the first enabled pixel.
- R2: Each address equals origin + pitch × row + col, taken modulo 2^20. The pitch is 1152 when `resSel` is 0 and 1024 when `resSel` is 1. Rows and columns count source pixels from the origin.
- R3: The origin is {`panWord`, `panLow`}: `panWord` supplies bits 19:4 and `panLow` supplies bits 3:0.
- R4: On a zoomed line the zoom is z = `zoomM1` + 1. Each column is held for z enabled clocks. The first column of the line is held for z − min(4 × `pixOff`, z − 1) clocks, so col = (i + min(4 × `pixOff`, z − 1)) / z for the i-th enabled pixel of the line.
- R5: Below the zoom-stop line each row is held for z lines. The first row is held for z − min(`lineOff`, z − 1) lines, so row = (L + min(`lineOff`, z − 1)) / z for line L, where line 0 is the first line after the commit.
- R6: `addrValid` is high in the clock cycle after each cycle in which `de` is high, and `pixAddr` then carries the address of that pixel. `addrValid` is low otherwise.
- R7: Line L is zoomed only when L < 4 × `stopQuad`. From line S = 4 × `stopQuad` (S > 0) onward, zoom is 1 and row = (S − 1 + min(`lineOff`, z − 1)) / z + 1 + (L − S). When `stopQuad` is 0 no line is zoomed and row = L.
- R8: The setting inputs take effect only on a rising edge of `vBlank`, which also restarts line numbering at 0. A change to the settings at any other time has no effect on the addresses produced.
- R9: The address wraps from 2^20 − 1 to 0 without any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| vBlank | input | 1 | Vertical blanking level; its rising edge commits the settings |
| de | input | 1 | Display enable, high for each displayed pixel |
| resSel | input | 1 | Pitch select: 0 gives 1152, 1 gives 1024 |
| panWord | input | 16 | Pan origin bits 19:4 |
| panLow | input | 4 | Pan origin bits 3:0 |
| zoomM1 | input | 4 | Zoom factor minus one |
| lineOff | input | 4 | Starting line inside the first zoomed row |
| pixOff | input | 4 | Starting clock inside the first zoomed column, divided by 4 |
| stopQuad | input | 9 | Line at which zoom stops, divided by 4 |
| pixAddr | output | 20 | Linear pixel address |
| addrValid | output | 1 | pixAddr carries a displayed pixel |

## Verification
A corrupted repeat counter shows up at once as a column that lasts too long or too short. The bench notices it within the same line, on the first pixel whose address no longer matches the closed-form column. A wrong row base or line count shows first on the next line's opening pixel, and a wrong stop comparison shows on the first line at or past the stop line. Settings that leak in without a commit change the next pixel issued, so the mid-frame change test catches them on the first line after the change.

// File: rtl/zp_pkg.sv
package zp_pkg;
  localparam int ADDR_W   = 20;
  localparam int HI_W     = 16;
  localparam int LO_W     = ADDR_W - HI_W;
  localparam int ZW       = 4;
  localparam int STOP_W   = 9;
  localparam int LINE_W   = STOP_W + 2;
  localparam int PITCH_A  = 1152;
  localparam int PITCH_B  = 1024;

  typedef struct packed {
    logic frameInit;
    logic lineFirst;
    logic pixel;
    logic rowAdvance;
    logic zoomOn;
  } zpStrobe_t;
endpackage

// File: rtl/zp_shadow.sv
module zp_shadow
  import zp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              commit,
  input  logic              resSelIn,
  input  logic [HI_W-1:0]   panWordIn,
  input  logic [LO_W-1:0]   panLowIn,
  input  logic [ZW-1:0]     zoomM1In,
  input  logic [ZW-1:0]     lineOffIn,
  input  logic [ZW-1:0]     pixOffIn,
  input  logic [STOP_W-1:0] stopQuadIn,
  output logic              resSel,
  output logic [HI_W-1:0]   panWord,
  output logic [LO_W-1:0]   panLow,
  output logic [ZW-1:0]     zoomM1,
  output logic [ZW-1:0]     lineOff,
  output logic [ZW-1:0]     pixOff,
  output logic [STOP_W-1:0] stopQuad
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      resSel   <= 1'b0;
      panWord  <= '0;
      panLow   <= '0;
      zoomM1   <= '0;
      lineOff  <= '0;
      pixOff   <= '0;
      stopQuad <= '0;
    end else if (commit) begin
      resSel   <= resSelIn;
      panWord  <= panWordIn;
      panLow   <= panLowIn;
      zoomM1   <= zoomM1In;
      lineOff  <= lineOffIn;
      pixOff   <= pixOffIn;
      stopQuad <= stopQuadIn;
    end
  end

  // R8: the working set moves only on a commit strobe
  a_r8_hold_between_commits: assert property (@(posedge clk) disable iff (!rstN)
    !commit |=> ($stable(zoomM1) && $stable(panWord) && $stable(stopQuad) && $stable(resSel)));
endmodule

// File: rtl/zp_ctrl.sv
module zp_ctrl
  import zp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              de,
  input  logic              vBlank,
  input  logic [ZW-1:0]     zoomM1,
  input  logic [ZW-1:0]     lineOff,
  input  logic [STOP_W-1:0] stopQuad,
  output logic              commit,
  output zpStrobe_t         stb
);
  logic              dePrev, vbPrev, commitD;
  logic [LINE_W-1:0] lineNo, nextLine, stopLine;
  logic [ZW-1:0]     yRep, yStart;
  logic              lineEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dePrev  <= 1'b0;
      vbPrev  <= 1'b0;
      commitD <= 1'b0;
    end else begin
      dePrev  <= de;
      vbPrev  <= vBlank;
      commitD <= commit;
    end
  end

  assign commit   = vBlank && !vbPrev;
  assign lineEnd  = dePrev && !de;
  assign stopLine = {stopQuad, 2'b00};
  assign nextLine = (&lineNo) ? lineNo : lineNo + LINE_W'(1);
  assign yStart   = (lineOff > zoomM1) ? zoomM1 : lineOff;

  always_comb begin
    stb.frameInit  = commitD;
    stb.lineFirst  = de && !dePrev;
    stb.pixel      = de;
    stb.zoomOn     = lineNo < stopLine;
    stb.rowAdvance = lineEnd && (!(nextLine < stopLine) || (yRep >= zoomM1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineNo <= '0;
      yRep   <= '0;
    end else if (commitD) begin
      lineNo <= '0;
      yRep   <= yStart;
    end else if (lineEnd) begin
      lineNo <= nextLine;
      yRep   <= stb.rowAdvance ? '0 : yRep + ZW'(1);
    end
  end

  // R5: the vertical repeat count never passes the zoom
  a_r5_yrep_bound: assert property (@(posedge clk) disable iff (!rstN)
    !commitD |-> (yRep <= zoomM1));
  // R7: once past the stop line every line moves to a new row
  a_r7_unzoomed_advance: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && !stb.zoomOn) |-> stb.rowAdvance);
endmodule

// File: rtl/zp_datapath.sv
module zp_datapath
  import zp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  zpStrobe_t         stb,
  input  logic              resSel,
  input  logic [HI_W-1:0]   panWord,
  input  logic [LO_W-1:0]   panLow,
  input  logic [ZW-1:0]     zoomM1,
  input  logic [ZW-1:0]     pixOff,
  output logic [ADDR_W-1:0] pixAddr,
  output logic              addrValid
);
  localparam logic [ADDR_W-1:0] PITCH_A_V = ADDR_W'(PITCH_A);
  localparam logic [ADDR_W-1:0] PITCH_B_V = ADDR_W'(PITCH_B);

  logic [ADDR_W-1:0] rowBase, xAddr, curAddr, pitch, origin;
  logic [ZW-1:0]     xRep, curRep, xStart, zEffM1;
  logic [ZW+1:0]     pOff4;

  assign origin = {panWord, panLow};
  assign pitch  = resSel ? PITCH_B_V : PITCH_A_V;
  assign zEffM1 = stb.zoomOn ? zoomM1 : '0;
  assign pOff4  = {pixOff, 2'b00};

  always_comb begin
    if (!stb.zoomOn)                     xStart = '0;
    else if (pOff4 > {2'b00, zoomM1})    xStart = zoomM1;
    else                                 xStart = pOff4[ZW-1:0];
    curAddr = stb.lineFirst ? rowBase : xAddr;
    curRep  = stb.lineFirst ? xStart  : xRep;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowBase <= '0;
    end else if (stb.frameInit) begin
      rowBase <= origin;
    end else if (stb.rowAdvance) begin
      rowBase <= rowBase + pitch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xAddr     <= '0;
      xRep      <= '0;
      pixAddr   <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= stb.pixel;
      if (stb.pixel) begin
        pixAddr <= curAddr;
        if (curRep >= zEffM1) begin
          xAddr <= curAddr + ADDR_W'(1);
          xRep  <= '0;
        end else begin
          xAddr <= curAddr;
          xRep  <= curRep + ZW'(1);
        end
      end
    end
  end

  // R4: inside a line the address holds or steps by one (R9: with wrap)
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pixel && !stb.lineFirst) |=>
      (pixAddr == $past(pixAddr) || pixAddr == $past(pixAddr) + ADDR_W'(1)));
  // R4: horizontal repeat count stays within the effective zoom
  a_r4_xrep_bound: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pixel && !stb.lineFirst) |-> (xRep <= zEffM1));
  // R5: the row base moves only at a row step or a new frame
  a_r5_row_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.frameInit && !stb.rowAdvance) |=> $stable(rowBase));
endmodule

// File: rtl/zp_scan_top.sv
module zp_scan_top
  import zp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        vBlank,
  input  logic        de,
  input  logic        resSel,
  input  logic [15:0] panWord,
  input  logic [3:0]  panLow,
  input  logic [3:0]  zoomM1,
  input  logic [3:0]  lineOff,
  input  logic [3:0]  pixOff,
  input  logic [8:0]  stopQuad,
  output logic [19:0] pixAddr,
  output logic        addrValid
);
  logic              commit;
  zpStrobe_t         stb;
  logic              wResSel;
  logic [HI_W-1:0]   wPanWord;
  logic [LO_W-1:0]   wPanLow;
  logic [ZW-1:0]     wZoomM1, wLineOff, wPixOff;
  logic [STOP_W-1:0] wStopQuad;

  zp_shadow uShadow (
    .clk(clk), .rstN(rstN), .commit(commit),
    .resSelIn(resSel), .panWordIn(panWord), .panLowIn(panLow),
    .zoomM1In(zoomM1), .lineOffIn(lineOff), .pixOffIn(pixOff),
    .stopQuadIn(stopQuad),
    .resSel(wResSel), .panWord(wPanWord), .panLow(wPanLow),
    .zoomM1(wZoomM1), .lineOff(wLineOff), .pixOff(wPixOff),
    .stopQuad(wStopQuad)
  );

  zp_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .de(de), .vBlank(vBlank),
    .zoomM1(wZoomM1), .lineOff(wLineOff), .stopQuad(wStopQuad),
    .commit(commit), .stb(stb)
  );

  zp_datapath uData (
    .clk(clk), .rstN(rstN), .stb(stb),
    .resSel(wResSel), .panWord(wPanWord), .panLow(wPanLow),
    .zoomM1(wZoomM1), .pixOff(wPixOff),
    .pixAddr(pixAddr), .addrValid(addrValid)
  );

  // R6: one valid output per enabled pixel, one clock later
  a_r6_valid_tracks_de: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (addrValid == $past(de)));
endmodule

// File: tb/tb_zp_scan_top.sv
module tb_zp_scan_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vBlank = 1'b0, de = 1'b0, resSel = 1'b0;
  logic [15:0] panWord = '0;
  logic [3:0]  panLow = '0, zoomM1 = '0, lineOff = '0, pixOff = '0;
  logic [8:0]  stopQuad = '0;
  logic [19:0] pixAddr;
  logic        addrValid;

  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 1'b0;

  // committed copy of settings, as the bench understands R8
  int eRes, eOrigin, eZ, eLo, ePo, eStop, lineCtr;
  int expQ[$];
  string tagQ[$];

  zp_scan_top dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int minI(int a, int b); return (a < b) ? a : b; endfunction

  // R2, R3, R4, R5, R7, R9 closed form
  function automatic int expAddr(int L, int i);
    int row, col, pitch, S;
    S = eStop * 4;
    pitch = (eRes != 0) ? 1024 : 1152;
    if (L < S) begin
      row = (L + eLo) / eZ;
      col = (i + ePo) / eZ;
    end else begin
      row = (S == 0) ? L : ((S - 1 + eLo) / eZ + 1 + (L - S));
      col = i;
    end
    return (eOrigin + pitch * row + col) & 32'hFFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setCfg(int r, int pw, int pl, int zm1, int lo, int po, int sq);
    @(posedge clk); #1;
    resSel = r[0]; panWord = pw[15:0]; panLow = pl[3:0];
    zoomM1 = zm1[3:0]; lineOff = lo[3:0]; pixOff = po[3:0]; stopQuad = sq[8:0];
  endtask

  // R8: commit on a rising vBlank
  task automatic commitFrame();
    eRes = resSel; eOrigin = {panWord, panLow};
    eZ = zoomM1 + 1; eLo = minI(lineOff, zoomM1); ePo = minI(pixOff * 4, zoomM1);
    eStop = stopQuad; lineCtr = 0;
    @(posedge clk); #1; vBlank = 1'b1;
    repeat (3) @(posedge clk);
    #1; vBlank = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic runLines(int n, int pix, string tag);
    for (int l = 0; l < n; l++) begin
      for (int i = 0; i < pix; i++) begin
        @(posedge clk); #1;
        de = 1'b1;
        expQ.push_back(expAddr(lineCtr, i));
        tagQ.push_back(tag);
      end
      @(posedge clk); #1; de = 1'b0;
      repeat (2) @(posedge clk);
      lineCtr++;
    end
    repeat (2) @(posedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (addrValid) begin
        if (expQ.size() == 0) begin
          check("R6 unexpected valid", 1, 0);
        end else begin
          string t;
          int e;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(t, int'(pixAddr), e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1'b1;
      nFails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 valid in reset", int'(addrValid), 0);
    check("R1 addr in reset", int'(pixAddr), 0);
    @(posedge clk); #1; rstN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 valid after reset", int'(addrValid), 0);
    check("R1 addr after reset", int'(pixAddr), 0);

    // plain scan, pitch 1152, no zoom (R2, R6)
    setCfg(0, 0, 0, 0, 0, 0, 0);
    commitFrame();
    runLines(3, 6, "R2 unzoomed pitch 1152");

    // zoom 3, offsets clamped, stop at line 8, pitch 1024 (R3 R4 R5 R7)
    setCfg(1, 16'h0012, 3, 2, 1, 1, 2);
    commitFrame();
    runLines(12, 9, "R7 zoom3 with stop");

    // settings change without a commit: ignored (R8)
    setCfg(0, 16'h0400, 0, 7, 0, 0, 100);
    runLines(2, 9, "R8 uncommitted change ignored");

    // zoom 16, large offsets (R4 R5)
    setCfg(0, 16'h0001, 5, 15, 5, 2, 511);
    commitFrame();
    runLines(20, 40, "R4 zoom16 offsets");

    // wrap at the top of the address space (R9)
    setCfg(0, 16'hFFFF, 14, 0, 0, 0, 0);
    commitFrame();
    runLines(3, 5, "R9 address wrap");

    // zoom 2, stop after 4 lines, pitch 1024 (R5 R7)
    setCfg(1, 16'h0100, 0, 1, 0, 0, 1);
    commitFrame();
    runLines(8, 6, "R5 zoom2 stop4");

    repeat (4) @(posedge clk);
    check("R6 all expected pixels seen", expQ.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule